// File: doc/BRIEF.md
# Lookahead-Gated Barrel Thread Scheduler

This block picks, on every clock, which hardware thread of a barrel-style multithreaded core issues its next instruction. Threads are interleaved cycle by cycle and a switch costs nothing, so the same thread or a different one may issue on any cycle. The chosen thread's ID and an issue strobe leave the block from registers. They appear one clock after the inputs that led to the choice.

Each thread's next instruction comes with a 3-bit lookahead value. It says how many of the instructions that follow it do not depend on it. Each thread keeps a count of its instructions still in flight and an issue credit. The credit is the number of further instructions the thread may issue before it has to wait. The credit can never exceed 7. A per-thread completion pulse retires one in-flight instruction. When a thread's in-flight count returns to zero, the thread is free to issue again. Among the threads that are ready, priority rotates, starting with the thread after the one that issued last.

The thread count is a parameter. Up to 128 contexts are supported, and the default is 8.

Top module: `barrel_issue_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `issue_valid_o` is 0. Reset leaves every thread with zero instructions in flight. The first thread to be searched after reset is thread 0.
- R2: Each decision searches the threads in increasing ID order, wrapping from the highest ID to 0. The search starts one past the thread that issued last. When every thread is ready, issues go 0,1,…,NT-1,0,1,…
- R3: A thread is granted only if its `avail_i` bit was 1 and it was ready in the deciding cycle. The chosen ID is always below NT, and at most one thread issues per cycle.
- R4: A thread issuing from zero in-flight instructions with lookahead L, and receiving no completions, can issue exactly L+1 instructions in a row. These may fall on consecutive cycles.
- R5: After a thread issues an instruction with lookahead 0, that thread issues nothing more until its in-flight count is back to zero. A back-to-back issue by one thread therefore requires the earlier instruction's lookahead to be at least 1.
- R6: When a thread issues while other instructions are in flight, its credit becomes the smaller of (old credit − 1) and the new lookahead. A short lookahead therefore cuts a longer window.
- R7: A completion pulse lowers the thread's in-flight count by one. When the count reaches zero, the thread may issue again from the next decision onward, whatever credit it had.
- R8: A completion pulse to a thread with zero instructions in flight is ignored. It changes no issue decision.
- R9: When no thread is ready, `issue_valid_o` is 0 in the following cycle and the rotation point is left unchanged. The next issue continues after the thread that issued last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| avail_i | input | NT | Per thread: an instruction is waiting to issue |
| la_i | input | NT*3 | Per thread: lookahead of its waiting instruction; thread t uses bits [3t+2:3t] |
| done_i | input | NT | Per thread: one in-flight instruction completed this cycle |
| issue_valid_o | output | 1 | A thread issues in this cycle |
| issue_tid_o | output | $clog2(NT) | ID of the issuing thread, meaningful when `issue_valid_o` is 1 |

## Verification
The block has one cycle of latency. The inputs present at a rising edge decide the `issue_valid_o`/`issue_tid_o` pair that holds for the whole next cycle. A completion or issue at that edge changes readiness only for the decision at the edge after. The bench drives inputs on falling edges and advances a behavioural model at each rising edge. It compares the outputs at the following falling edge, so every cycle is checked exactly one register stage after its stimulus. The directed scenarios count issues over a window of cycles measured in that same frame. The R7 re-arm in particular is expected only in the decision made at the edge after the completion edge.

// File: rtl/bis_pkg.sv
package bis_pkg;
    // width of the per-instruction lookahead field
    localparam int LA_W   = 3;
    // largest credit a thread can hold
    localparam int MAX_LA = (1 << LA_W) - 1;
    // in-flight count reaches at most MAX_LA + 1
    localparam int CNT_W  = $clog2(MAX_LA + 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;     // instructions in flight
        logic [LA_W-1:0]  credit;  // further issues allowed while cnt != 0
    } ctx_t;
endpackage

// File: rtl/bis_thr_ctx.sv
module bis_thr_ctx
    import bis_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            avail_i,
    input  logic [LA_W-1:0] la_i,
    input  logic            grant_i,
    input  logic            done_i,
    output logic            ready_o
);
    ctx_t ctx_d, ctx_q;
    logic retire;
    logic [LA_W-1:0] dec;

    // ready when idle, or when the dependence window still has room
    assign ready_o = avail_i && ((ctx_q.cnt == '0) || (ctx_q.credit != '0));

    always_comb begin
        ctx_d  = ctx_q;
        retire = done_i && (ctx_q.cnt != '0);
        dec    = ctx_q.credit - LA_W'(1);
        if (grant_i) begin
            if (ctx_q.cnt == '0) begin
                ctx_d.credit = la_i;
            end else begin
                ctx_d.credit = (la_i < dec) ? la_i : dec;
            end
        end
        ctx_d.cnt = ctx_q.cnt + CNT_W'(grant_i) - CNT_W'(retire);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end
endmodule

// File: rtl/bis_rr_pick.sv
module bis_rr_pick #(
    parameter int NT    = 8,
    parameter int TID_W = $clog2(NT)
) (
    input  logic [NT-1:0]    req_i,
    input  logic [TID_W-1:0] last_i,
    output logic             any_o,
    output logic [TID_W-1:0] pick_o,
    output logic [NT-1:0]    grant_o
);
    int idx;

    always_comb begin
        any_o   = 1'b0;
        pick_o  = '0;
        grant_o = '0;
        for (int i = 0; i < NT; i++) begin
            idx = int'(last_i) + 1 + i;
            if (idx >= NT) begin
                idx = idx - NT;
            end
            if (!any_o && req_i[idx]) begin
                any_o        = 1'b1;
                pick_o       = TID_W'(idx);
                grant_o[idx] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import bis_pkg::*;
#(
    parameter int NT    = 8,
    parameter int TID_W = $clog2(NT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NT-1:0]     avail_i,
    input  logic [NT*LA_W-1:0] la_i,
    input  logic [NT-1:0]     done_i,
    output logic              issue_valid_o,
    output logic [TID_W-1:0]  issue_tid_o
);
    typedef struct packed {
        logic             valid;
        logic [TID_W-1:0] tid;
        logic [TID_W-1:0] last;
    } sched_t;

    sched_t st_d, st_q;
    logic [NT-1:0]    ready;
    logic [NT-1:0]    grant;
    logic             any;
    logic [TID_W-1:0] pick;

    for (genvar g = 0; g < NT; g++) begin : g_ctx
        bis_thr_ctx u_ctx (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .avail_i (avail_i[g]),
            .la_i    (la_i[g*LA_W +: LA_W]),
            .grant_i (grant[g]),
            .done_i  (done_i[g]),
            .ready_o (ready[g])
        );
    end

    bis_rr_pick #(.NT(NT), .TID_W(TID_W)) u_pick (
        .req_i   (ready),
        .last_i  (st_q.last),
        .any_o   (any),
        .pick_o  (pick),
        .grant_o (grant)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = any;
        if (any) begin
            st_d.tid  = pick;
            st_d.last = pick;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.valid <= 1'b0;
            st_q.tid   <= '0;
            st_q.last  <= TID_W'(NT - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid_o = st_q.valid;
    assign issue_tid_o   = st_q.tid;
endmodule

// File: rtl/bis_chk.sv
module bis_chk
    import bis_pkg::*;
#(
    parameter int NT    = 8,
    parameter int TID_W = $clog2(NT)
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NT-1:0]      avail_i,
    input logic [NT*LA_W-1:0] la_i,
    input logic               issue_valid_o,
    input logic [TID_W-1:0]   issue_tid_o
);
    logic [NT-1:0]      avail_h;
    logic [NT*LA_W-1:0] la_h1, la_h2;
    logic               valid_h;
    logic [TID_W-1:0]   tid_h;
    logic [LA_W-1:0]    prev_la;

    always_ff @(posedge clk_i) begin
        avail_h <= avail_i;
        la_h1   <= la_i;
        la_h2   <= la_h1;
        valid_h <= issue_valid_o;
        tid_h   <= issue_tid_o;
    end

    always_comb begin
        prev_la = la_h2[int'(tid_h)*LA_W +: LA_W];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !issue_valid_o);

    // R3
    tid_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        issue_valid_o |-> (int'(issue_tid_o) < NT));

    // R3
    issued_was_avail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        issue_valid_o |-> avail_h[issue_tid_o]);

    // R9
    idle_when_none_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (avail_h == '0) |-> !issue_valid_o);

    // R5
    lookahead_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (issue_valid_o && valid_h && (issue_tid_o == tid_h)) |-> (prev_la != '0));
endmodule

bind barrel_issue_sched bis_chk #(.NT(NT), .TID_W(TID_W)) u_bis_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .avail_i       (avail_i),
    .la_i          (la_i),
    .issue_valid_o (issue_valid_o),
    .issue_tid_o   (issue_tid_o)
);

// File: tb/barrel_issue_sched_test.sv
`timescale 1ns/1ps
module barrel_issue_sched_test;
    localparam int NT    = 8;
    localparam int TID_W = $clog2(NT);
    localparam int LAW   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NT-1:0]     avail = '0;
    logic [NT*LAW-1:0] la = '0;
    logic [NT-1:0]     done = '0;
    logic              issue_valid;
    logic [TID_W-1:0]  issue_tid;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    int m_cnt[NT];
    int m_cr[NT];
    int m_last;
    bit m_v;
    int m_tid;

    always #4 clk = ~clk;

    barrel_issue_sched #(.NT(NT)) uut (
        .clk_i(clk), .rst_i(rst), .avail_i(avail), .la_i(la), .done_i(done),
        .issue_valid_o(issue_valid), .issue_tid_o(issue_tid)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_eval();
        int pick;
        if (rst) begin
            for (int t = 0; t < NT; t++) begin m_cnt[t] = 0; m_cr[t] = 0; end
            m_last = NT - 1; m_v = 0; m_tid = 0;
            return;
        end
        pick = -1;
        for (int i = 0; i < NT; i++) begin
            int t;
            t = (m_last + 1 + i) % NT;
            if (pick < 0 && avail[t] && (m_cnt[t] == 0 || m_cr[t] > 0)) pick = t;
        end
        for (int t = 0; t < NT; t++) begin
            int l, nc;
            l  = (la >> (LAW * t)) & 7;
            nc = m_cnt[t] + ((t == pick) ? 1 : 0) - ((done[t] && m_cnt[t] > 0) ? 1 : 0);
            if (t == pick) begin
                if (m_cnt[t] == 0) m_cr[t] = l;
                else m_cr[t] = (m_cr[t] - 1 < l) ? m_cr[t] - 1 : l;
            end
            m_cnt[t] = nc;
        end
        m_v = (pick >= 0);
        if (m_v) begin m_tid = pick; m_last = pick; end
    endtask

    // one clock: model steps at the rising edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_eval();
        @(negedge clk);
        vectors++;
        if (issue_valid !== m_v || (m_v && issue_tid !== TID_W'(m_tid))) begin
            fails++;
            $display("FAIL %s: actual valid=%0b tid=%0d expected valid=%0b tid=%0d",
                     cur_req, issue_valid, issue_tid, m_v, m_tid);
        end
    endtask

    function automatic logic [NT*LAW-1:0] la_all(int v);
        logic [NT*LAW-1:0] r;
        for (int t = 0; t < NT; t++) r[t*LAW +: LAW] = LAW'(v);
        return r;
    endfunction

    task automatic do_reset();
        rst = 1'b1; avail = '0; la = '0; done = '0;
        step(); step();
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        do_reset();
        check(issue_valid == 1'b0, "R1", int'(issue_valid), 0);
        avail = '1; la = la_all(7);
        step();
        check(issue_valid && issue_tid == 0, "R1", int'(issue_tid), 0);

        // R2: rotation order with everyone ready
        cur_req = "R2";
        do_reset();
        avail = '1; la = la_all(7);
        for (int i = 0; i < 2 * NT; i++) begin
            step();
            check(issue_valid && int'(issue_tid) == i % NT, "R2", int'(issue_tid), i % NT);
        end

        // R4: lookahead 2 gives three issues in a row
        cur_req = "R4";
        do_reset();
        avail = NT'(1) << 3; la = la_all(2);
        n = 0;
        for (int i = 0; i < 6; i++) begin step(); if (issue_valid) n++; end
        check(n == 3, "R4", n, 3);

        // R5 then R7: lookahead 0 blocks until completion re-arms
        cur_req = "R5";
        do_reset();
        avail = NT'(1) << 5; la = la_all(0);
        n = 0;
        for (int i = 0; i < 4; i++) begin step(); if (issue_valid) n++; end
        check(n == 1, "R5", n, 1);
        cur_req = "R7";
        done = NT'(1) << 5;
        step();
        check(issue_valid == 1'b0, "R7", int'(issue_valid), 0);
        done = '0;
        step();
        check(issue_valid && issue_tid == 5, "R7", int'(issue_tid), 5);

        // R8: completions to an idle thread are dropped
        cur_req = "R8";
        do_reset();
        done = '1;
        step(); step();
        done = '0; avail = NT'(1) << 1; la = la_all(0);
        step();
        check(issue_valid && issue_tid == 1, "R8", int'(issue_tid), 1);
        step();
        check(issue_valid == 1'b0, "R8", int'(issue_valid), 0);
        done = NT'(1) << 1;
        step();
        done = '0;
        step();
        check(issue_valid && issue_tid == 1, "R8", int'(issue_tid), 1);

        // R6: a short lookahead trims a longer window
        cur_req = "R6";
        do_reset();
        avail = NT'(1) << 2; la = la_all(7);
        step();
        check(issue_valid && issue_tid == 2, "R6", int'(issue_tid), 2);
        la = la_all(1);
        n = 0;
        for (int i = 0; i < 5; i++) begin step(); if (issue_valid) n++; end
        check(n == 2, "R6", n, 2);

        // R9: idle cycles keep the rotation point
        cur_req = "R9";
        do_reset();
        avail = '1; la = la_all(7);
        step();
        avail = '0;
        step();
        check(issue_valid == 1'b0, "R9", int'(issue_valid), 0);
        step();
        check(issue_valid == 1'b0, "R9", int'(issue_valid), 0);
        avail = '1;
        step();
        check(issue_valid && issue_tid == 1, "R9", int'(issue_tid), 1);

        // R3: random traffic against the model
        cur_req = "R3";
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            avail = NT'($urandom) & NT'($urandom);
            la    = (NT*LAW)'({$urandom, $urandom});
            done  = NT'($urandom) & NT'($urandom);
            step();
            if (issue_valid) check(int'(issue_tid) < NT, "R3", int'(issue_tid), NT - 1);
        end

        summary();
        $finish;
    end
endmodule